// File: doc/BRIEF.md
# Interleaved Configuration Header Section Finder

This block sits on an incoming byte stream that carries up to four configuration images mixed together in fixed slices of 288 bytes, one slice from each image in rotation. After a start pulse it keeps only the slices of one chosen image and drops the rest. It checks that the chosen image opens with the expected 13-byte file signature, then steps through the typed header sections until it meets the section type that was asked for.

When the section is found, the block reports its length with a one-cycle found pulse and then hands exactly that many following bytes of the chosen image to a downstream consumer over a valid/ready handshake. A malformed or missing section ends the search with a one-cycle error pulse. The slicing and header walk are done in a single pass, so the stream never needs to be buffered.

Top module: `hdr_section_finder`

## Requirements
- R1: The stream is cut into slices of 288 bytes counted from the first byte after start; slice s belongs to image slot (s mod N), and only slices of slot img_sel-1 are parsed or forwarded, while all other bytes are accepted (in_ready high) and discarded.
- R2: img_count (N, 1 to 4), img_sel (1 to N) and want_type are captured on start, and the slice byte counter restarts from zero on every start.
- R3: The chosen image must begin with the bytes 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01; the first byte that differs raises error.
- R4: A section is a type byte, a big-endian length (four bytes when the type is 0x65 'e', two bytes for every other type) and that many content bytes; content of unwanted sections is skipped.
- R5: A type byte below 0x61 or above 0x65 raises error.
- R6: A section of any type other than 0x65 whose length exceeds 255 raises error.
- R7: Header bytes after the signature (type, length and skipped content) are counted; a new type byte is read only while the count is below 100, and a skip that brings the count to 100 raises error.
- R8: When the wanted type's length is complete, found pulses and sec_len shows that length; sec_len holds until the next start, which clears it to 0.
- R9: found and error are each one cycle long and never high together.
- R10: After found, the next sec_len bytes of the chosen image appear on out_data with out_valid; while out_ready is low no byte of the chosen image is consumed, and after the last one in_ready stays low.
- R11: Out of reset found, error, out_valid and in_ready are 0 and sec_len is 0.
- R12: After error, in_ready stays low until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new search; captures the selection inputs |
| img_count | input | 3 | Number of interleaved images N |
| img_sel | input | 3 | Chosen image, 1-based |
| want_type | input | 8 | Section type byte to look for |
| in_data | input | 8 | Incoming stream byte |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Byte is accepted this cycle |
| out_data | output | 8 | Forwarded section content byte |
| out_valid | output | 1 | out_data is valid |
| out_ready | input | 1 | Consumer accepts out_data |
| found | output | 1 | One-cycle pulse: wanted section located |
| error | output | 1 | One-cycle pulse: search failed |
| sec_len | output | 32 | Length of the located section |

## Verification
The embedded properties watch, on every cycle, that found and error never overlap and last one cycle, that sec_len only moves on a found pulse or after start, that the slice counters stay inside their ranges, that forwarded bytes are backed by incoming ones and are held under backpressure, and that input is refused right after an error. Whether the right bytes are kept, whether the signature, type and length rules and the 100-byte limit fire at the right boundary, and whether the forwarded content matches the chosen image can only be shown by the directed scenarios, which build interleaved streams and compare against the images they were built from.

// File: rtl/hsf_pkg.sv
package hsf_pkg;

   typedef enum logic [2:0] {
      PS_IDLE,
      PS_SIG,
      PS_TYPE,
      PS_LEN,
      PS_SKIP,
      PS_PAYLOAD
   } hsf_state_e;

   localparam int SIG_BYTES = 13;
   localparam logic [7:0] TYPE_LO   = 8'h61;
   localparam logic [7:0] TYPE_HI   = 8'h65;
   localparam logic [7:0] TYPE_WIDE = 8'h65;

   // signature byte at position idx
   function automatic logic [7:0] sig_byte(input logic [3:0] idx);
      logic [7:0] b;
      case (idx)
         4'd0, 4'd10, 4'd11: b = 8'h00;
         4'd1:               b = 8'h09;
         4'd12:              b = 8'h01;
         default:            b = idx[0] ? 8'hF0 : 8'h0F;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/hsf_slice_filter.sv
module hsf_slice_filter #(
   parameter int CHUNK   = 288,
   parameter int MAX_IMG = 4,
   localparam int IW     = $clog2(MAX_IMG + 1),
   localparam int OW     = $clog2(CHUNK),
   localparam int SW     = (MAX_IMG > 1) ? $clog2(MAX_IMG) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [IW-1:0] img_count,
   input  logic [IW-1:0] img_sel,
   input  logic          take,
   output logic          keep
);

   if (CHUNK < 2) begin : g_bad_chunk
      $error("hsf_slice_filter: CHUNK must be at least 2");
   end

   logic [OW-1:0] ofs_r;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ofs_r <= '0;
      else if (start)
         ofs_r <= '0;
      else if (take)
         ofs_r <= (ofs_r == OW'(CHUNK - 1)) ? '0 : ofs_r + 1'b1;
   end

   a_r1_ofs_range: assert property (@(posedge clk) disable iff (!rst_n)
      ofs_r <= OW'(CHUNK - 1));

   if (MAX_IMG == 1) begin : g_single
      assign keep = 1'b1;
   end else begin : g_multi
      logic [SW-1:0] slot_r, last_r, sel_r;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            slot_r <= '0;
            last_r <= '0;
            sel_r  <= '0;
         end else if (start) begin
            slot_r <= '0;
            last_r <= SW'(img_count - 1'b1);
            sel_r  <= SW'(img_sel - 1'b1);
         end else if (take && ofs_r == OW'(CHUNK - 1)) begin
            slot_r <= (slot_r == last_r) ? '0 : slot_r + 1'b1;
         end
      end

      assign keep = (slot_r == sel_r);

      a_r2_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
         slot_r <= last_r);
   end

endmodule

// File: rtl/hsf_walker.sv
module hsf_walker
   import hsf_pkg::*;
#(
   parameter int HDR_LIMIT = 100,
   parameter int LEN_W     = 32,
   localparam int HC_W     = $clog2(HDR_LIMIT + 8)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [7:0]       want_type,
   input  logic             byte_v,
   input  logic [7:0]       byte_d,
   output hsf_state_e       state,
   output logic             found,
   output logic             error,
   output logic [LEN_W-1:0] sec_len
);

   if (LEN_W < 32) begin : g_bad_len
      $error("hsf_walker: LEN_W must hold a four-byte length");
   end

   hsf_state_e       st_r;
   logic [3:0]       sig_idx;
   logic [HC_W-1:0]  hcnt;
   logic [7:0]       want_r, type_r;
   logic [LEN_W-1:0] len_r, cnt_r, nlen;
   logic [2:0]       lb_left;
   logic             limit_hit, bad_type;

   assign state     = st_r;
   assign limit_hit = hcnt >= HC_W'(HDR_LIMIT);
   assign nlen      = {len_r[LEN_W-9:0], byte_d};
   assign bad_type  = (byte_d < TYPE_LO) || (byte_d > TYPE_HI);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_r    <= PS_IDLE;
         sig_idx <= '0;
         hcnt    <= '0;
         want_r  <= '0;
         type_r  <= '0;
         len_r   <= '0;
         cnt_r   <= '0;
         lb_left <= '0;
         found   <= 1'b0;
         error   <= 1'b0;
         sec_len <= '0;
      end else begin
         found <= 1'b0;
         error <= 1'b0;
         if (start) begin
            st_r    <= PS_SIG;
            sig_idx <= '0;
            hcnt    <= '0;
            want_r  <= want_type;
            sec_len <= '0;
         end else begin
            case (st_r)
               PS_SIG: if (byte_v) begin
                  if (byte_d != sig_byte(sig_idx)) begin
                     error <= 1'b1;
                     st_r  <= PS_IDLE;
                  end else if (sig_idx == 4'(SIG_BYTES - 1)) begin
                     st_r <= PS_TYPE;
                  end else begin
                     sig_idx <= sig_idx + 1'b1;
                  end
               end
               PS_TYPE: begin
                  if (limit_hit) begin
                     error <= 1'b1;
                     st_r  <= PS_IDLE;
                  end else if (byte_v) begin
                     hcnt <= hcnt + 1'b1;
                     if (bad_type) begin
                        error <= 1'b1;
                        st_r  <= PS_IDLE;
                     end else begin
                        type_r  <= byte_d;
                        len_r   <= '0;
                        lb_left <= (byte_d == TYPE_WIDE) ? 3'd4 : 3'd2;
                        st_r    <= PS_LEN;
                     end
                  end
               end
               PS_LEN: if (byte_v) begin
                  hcnt    <= hcnt + 1'b1;
                  len_r   <= nlen;
                  lb_left <= lb_left - 1'b1;
                  if (lb_left == 3'd1) begin
                     if (type_r != TYPE_WIDE && |nlen[LEN_W-1:8]) begin
                        error <= 1'b1;
                        st_r  <= PS_IDLE;
                     end else if (type_r == want_r) begin
                        found   <= 1'b1;
                        sec_len <= nlen;
                        cnt_r   <= nlen;
                        st_r    <= (nlen == '0) ? PS_IDLE : PS_PAYLOAD;
                     end else begin
                        cnt_r <= nlen;
                        st_r  <= (nlen == '0) ? PS_TYPE : PS_SKIP;
                     end
                  end
               end
               PS_SKIP: begin
                  if (limit_hit) begin
                     error <= 1'b1;
                     st_r  <= PS_IDLE;
                  end else if (byte_v) begin
                     hcnt  <= hcnt + 1'b1;
                     cnt_r <= cnt_r - 1'b1;
                     if (cnt_r == LEN_W'(1)) st_r <= PS_TYPE;
                  end
               end
               PS_PAYLOAD: if (byte_v) begin
                  cnt_r <= cnt_r - 1'b1;
                  if (cnt_r == LEN_W'(1)) st_r <= PS_IDLE;
               end
               default: ;
            endcase
         end
      end
   end

   a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(found && error));
   a_r9_found_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      found |=> !found);
   a_r9_error_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      error |=> !error);
   a_r8_len_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> (found || $stable(sec_len)));
   a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      hcnt <= HC_W'(HDR_LIMIT + 4));

endmodule

// File: rtl/hdr_section_finder.sv
module hdr_section_finder
   import hsf_pkg::*;
#(
   parameter int CHUNK     = 288,
   parameter int MAX_IMG   = 4,
   parameter int HDR_LIMIT = 100,
   parameter int LEN_W     = 32,
   localparam int IW       = $clog2(MAX_IMG + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [IW-1:0]    img_count,
   input  logic [IW-1:0]    img_sel,
   input  logic [7:0]       want_type,
   input  logic [7:0]       in_data,
   input  logic             in_valid,
   output logic             in_ready,
   output logic [7:0]       out_data,
   output logic             out_valid,
   input  logic             out_ready,
   output logic             found,
   output logic             error,
   output logic [LEN_W-1:0] sec_len
);

   if (MAX_IMG < 1 || MAX_IMG > 4) begin : g_bad_img
      $error("hdr_section_finder: MAX_IMG must be 1 to 4");
   end

   hsf_state_e state;
   logic       keep, take, active, pay;

   assign active   = (state != PS_IDLE);
   assign pay      = (state == PS_PAYLOAD);
   assign in_ready = !start && active && (!keep || !pay || out_ready);
   assign take     = in_valid && in_ready;
   assign out_valid = !start && pay && keep && in_valid;
   assign out_data  = in_data;

   hsf_slice_filter #(.CHUNK(CHUNK), .MAX_IMG(MAX_IMG)) u_filter (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .img_count (img_count),
      .img_sel   (img_sel),
      .take      (take),
      .keep      (keep)
   );

   hsf_walker #(.HDR_LIMIT(HDR_LIMIT), .LEN_W(LEN_W)) u_walker (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .want_type (want_type),
      .byte_v    (take && keep),
      .byte_d    (in_data),
      .state     (state),
      .found     (found),
      .error     (error),
      .sec_len   (sec_len)
   );

   a_r10_out_backed: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> in_valid);
   a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);
   a_r12_refuse_after_error: assert property (@(posedge clk) disable iff (!rst_n)
      (error && !start) |-> !in_ready);

endmodule

// File: tb/sim_hdr_section_finder.sv
module sim_hdr_section_finder;

   localparam int CH = 288;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  img_count = 3'd1;
   logic [2:0]  img_sel = 3'd1;
   logic [7:0]  want_type = 8'h65;
   logic [7:0]  in_data = 8'h00;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [7:0]  out_data;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic        found, error;
   logic [31:0] sec_len;

   always #10 clk = ~clk;

   hdr_section_finder u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .img_count(img_count),
      .img_sel(img_sel), .want_type(want_type), .in_data(in_data),
      .in_valid(in_valid), .in_ready(in_ready), .out_data(out_data),
      .out_valid(out_valid), .out_ready(out_ready), .found(found),
      .error(error), .sec_len(sec_len)
   );

   int total_chk = 0, bad_chk = 0, cycles = 0;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         bad_chk = bad_chk + 1;
         $display("FAIL R1 watchdog actual=%0d expected<=150000", cycles);
         $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      total_chk++;
      if (!ok) begin
         bad_chk++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   logic [7:0] img [4][0:1151];
   int ilen [4];
   int pay_off, pos_c;

   task automatic clear_imgs();
      for (int k = 0; k < 4; k++) begin
         ilen[k] = 0;
         for (int i = 0; i < 1152; i++) img[k][i] = 8'(i * 7 + k * 31 + 3);
      end
   endtask

   task automatic put(input int k, input int b);
      img[k][ilen[k]] = 8'(b);
      ilen[k]++;
   endtask

   task automatic put_sig(input int k);
      int s [13] = '{'h00, 'h09, 'h0F, 'hF0, 'h0F, 'hF0, 'h0F, 'hF0, 'h0F, 'hF0, 'h00, 'h00, 'h01};
      for (int i = 0; i < 13; i++) put(k, s[i]);
   endtask

   task automatic put_sec2(input int k, input int t, input int n);
      put(k, t); put(k, n >> 8); put(k, n & 255);
      for (int i = 0; i < n; i++) put(k, 8'h40 + i + k);
   endtask

   // standard image: a(2) b(3) c(5) d(0) e(L) + L payload bytes
   task automatic build_std(input int k, input int L);
      put_sig(k);
      put_sec2(k, 8'h61, 2);
      put_sec2(k, 8'h62, 3);
      put(k, 8'h63); put(k, 0); put(k, 5);
      pos_c = ilen[k];
      for (int i = 0; i < 5; i++) put(k, 8'h90 + i);
      put_sec2(k, 8'h64, 0);
      put(k, 8'h65); put(k, L >> 24); put(k, (L >> 16) & 255); put(k, (L >> 8) & 255); put(k, L & 255);
      pay_off = ilen[k];
      for (int i = 0; i < L; i++) put(k, (k << 6) ^ (i * 5));
   endtask

   function automatic logic [7:0] sbyte(input int p, input int n);
      int slot, off;
      slot = (p / CH) % n;
      off  = (p / (CH * n)) * CH + p % CH;
      return img[slot][off];
   endfunction

   int nfound, nerr, got_len, npay, mism, stall_bad, wide_bad, end_rdy;

   task automatic run(input int n, input int sel, input int want, input bit bp);
      int total, p, fcnt, ecnt;
      total = n * CH * ((ilen[sel-1] + CH - 1) / CH + 1);
      nfound = 0; nerr = 0; got_len = -1; npay = 0; mism = 0;
      stall_bad = 0; wide_bad = 0; fcnt = 0; ecnt = 0; p = 0;
      @(negedge clk);
      img_count = 3'(n); img_sel = 3'(sel); want_type = 8'(want);
      start = 1'b1; in_valid = 1'b0;
      @(negedge clk);
      start = 1'b0;
      for (int cyc = 0; cyc < 2 * total + 40; cyc++) begin
         in_valid  = (p < total);
         in_data   = sbyte(p, n);
         out_ready = bp ? (cyc % 3 != 0) : 1'b1;
         #5;
         if (found) begin nfound++; got_len = int'(sec_len); fcnt++; end else fcnt = 0;
         if (error) begin nerr++; ecnt++; end else ecnt = 0;
         if (fcnt > 1 || ecnt > 1 || (found && error)) wide_bad++;
         if (out_valid && out_ready) begin
            if (out_data != img[sel-1][pay_off + npay]) mism++;
            npay++;
         end
         if (out_valid && !out_ready && in_ready) stall_bad++;
         if (in_valid && in_ready) p++;
         @(negedge clk);
      end
      #5;
      end_rdy = int'(in_ready);
   endtask

   task automatic t_reset();
      chk(found == 0 && error == 0, "R11 pulses at reset", found + error, 0);
      chk(in_ready == 0 && out_valid == 0, "R11 handshake at reset", in_ready + out_valid, 0);
      chk(sec_len == 0, "R11 sec_len at reset", sec_len, 0);
   endtask

   task automatic t_two_images();
      clear_imgs(); build_std(1, 20);
      run(2, 2, 8'h65, 0);
      chk(nfound == 1 && nerr == 0, "R1 found in slot 2", nfound, 1);
      chk(got_len == 20, "R4 4-byte e length", got_len, 20);
      chk(npay == 20 && mism == 0, "R10 payload bytes of slot 2", npay * 1000 + mism, 20000);
      chk(sec_len == 20, "R8 sec_len held", sec_len, 20);
      chk(end_rdy == 0, "R10 input refused after payload", end_rdy, 0);
      chk(wide_bad == 0, "R9 one-cycle exclusive pulses", wide_bad, 0);
   endtask

   task automatic t_want_c();
      clear_imgs(); build_std(0, 10);
      pay_off = pos_c;
      @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0; #5;
      chk(sec_len == 0, "R8 start clears sec_len", sec_len, 0);
      run(3, 1, 8'h63, 0);
      chk(nfound == 1 && got_len == 5, "R4 2-byte length, skips a and b", got_len, 5);
      chk(npay == 5 && mism == 0, "R10 c content forwarded", npay * 1000 + mism, 5000);
   endtask

   task automatic t_cross_bp();
      clear_imgs(); build_std(0, 300);
      run(2, 1, 8'h65, 1);
      chk(got_len == 300, "R4 e length above 255 accepted", got_len, 300);
      chk(npay == 300 && mism == 0, "R1 payload across slice boundary", npay * 1000 + mism, 300000);
      chk(stall_bad == 0, "R10 backpressure holds input", stall_bad, 0);
   endtask

   task automatic t_bad_sig();
      clear_imgs(); build_std(2, 8);
      img[2][5] = img[2][5] ^ 8'h01;
      run(3, 3, 8'h65, 0);
      chk(nerr == 1 && nfound == 0, "R3 signature mismatch error", nerr, 1);
      chk(end_rdy == 0, "R12 input refused after error", end_rdy, 0);
   endtask

   task automatic t_bad_type();
      clear_imgs(); put_sig(0); put_sec2(0, 8'h61, 1); put_sec2(0, 8'h66, 1);
      run(1, 1, 8'h65, 0);
      chk(nerr == 1 && nfound == 0, "R5 type 0x66 rejected", nerr, 1);
   endtask

   task automatic t_long_len();
      clear_imgs(); put_sig(0); put_sec2(0, 8'h62, 256);
      run(1, 1, 8'h62, 0);
      chk(nerr == 1 && nfound == 0, "R6 length 256 on type b", nerr, 1);
   endtask

   task automatic t_limit(input int alen, input bit expect_err);
      clear_imgs(); put_sig(0); put_sec2(0, 8'h61, alen);
      put(0, 8'h65); put(0, 0); put(0, 0); put(0, 0); put(0, 4);
      pay_off = ilen[0];
      for (int i = 0; i < 4; i++) put(0, 8'hC0 + i);
      run(1, 1, 8'h65, 0);
      if (expect_err)
         chk(nerr == 1 && nfound == 0, "R7 limit reached before type", nerr, 1);
      else
         chk(nfound == 1 && nerr == 0 && got_len == 4, "R7 type read at count 99", got_len, 4);
   endtask

   task automatic t_four();
      clear_imgs(); build_std(3, 6);
      run(4, 4, 8'h65, 0);
      chk(nfound == 1 && npay == 6 && mism == 0, "R2 N=4 slot 4 after restart", npay * 1000 + mism, 6000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #5; t_reset();
      @(negedge clk); rst_n = 1'b1;
      t_two_images();
      t_want_c();
      t_cross_bp();
      t_bad_sig();
      t_four();
      t_bad_type();
      t_long_len();
      t_limit(96, 1'b0);
      t_limit(97, 1'b1);
      $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
      $finish;
   end

endmodule